// File: doc/BRIEF.md
# Speech Byte Staging Queue with Status Interrupt

This block buffers encoded speech bytes between a host processor and a speech synthesis engine. The host pushes bytes into a sixteen-entry first-in-first-out store. The engine drains them through a show-ahead consumer port at whatever pace its frame decoding needs. The engine also reports through a level input whether it has finished processing.

Three conditions are derived from the store occupancy and the engine state: the queue is running low, the queue is empty, and talking has finished with nothing left queued. A single interrupt line is active whenever any of these holds, so the host refills on demand. A ready line throttles the host when the store is full. A byte offered while ready is low is discarded, and a sticky overflow bit records the loss. The host may sample the status byte at any time. A status-read strobe only clears the overflow bit and never touches the queued data.

Top module: `voice_stage_fifo`

## Requirements
- R1: After reset the store is empty: `wr_ready` is 1, `rd_valid` is 0, the overflow bit is clear and `stat_data` reads 8'h20 while `engine_idle` is 0.
- R2: Bytes leave through `rd_data` in the order they were accepted, with `rd_data` showing the oldest byte whenever `rd_valid` is 1.
- R3: The low flag, bit 6 of `stat_data`, is 1 exactly when occupancy is between 1 and 8 inclusive.
- R4: The empty flag, bit 5 of `stat_data`, is 1 exactly when occupancy is zero. `rd_valid` is its inverse.
- R5: The talk-finished flag, bit 7 of `stat_data`, is 1 exactly when `engine_idle` is 1 and occupancy is zero.
- R6: `irq` is the OR of bits 7, 6 and 5. Starting from empty, `irq` stays 1 after each of the first 8 single-byte writes and is 0 after writes 9 through 16.
- R7: `wr_ready` is 0 exactly when all 16 entries hold data.
- R8: A write offered while `wr_ready` is 0 is dropped without changing the stored bytes, and it sets the sticky overflow bit, bit 4 of `stat_data`. Bits 3:0 of `stat_data` always read 0.
- R9: A `stat_rd` strobe clears the overflow bit on the next cycle unless a dropped write happens in the same cycle. The strobe has no effect on occupancy or data.
- R10: An accepted write and an accepted read in the same cycle leave occupancy unchanged.
- R11: `rd_en` while `rd_valid` is 0 is ignored. Occupancy stays zero and the next byte written is the next byte read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Host offers `wr_data` this cycle |
| wr_data | input | 8 | Byte from the host |
| wr_ready | output | 1 | Store has room; writes are accepted only while 1 |
| rd_en | input | 1 | Engine takes the head byte this cycle |
| rd_data | output | 8 | Oldest stored byte (show-ahead) |
| rd_valid | output | 1 | Store holds at least one byte |
| engine_idle | input | 1 | Engine has finished processing |
| stat_rd | input | 1 | Host read strobe for the status byte; clears overflow |
| stat_data | output | 8 | Status: talk-finished, low, empty, overflow, four zero bits |
| irq | output | 1 | Request for more data |

## Verification
The checker assumes the host and engine handshakes are single-cycle level qualifiers sampled at the clock edge, and that `engine_idle` is a steady level rather than a pulse that must be caught. The bench drives every input a short time after the rising edge and holds it for one full cycle, so each request meets exactly one edge. Overflow is provoked only by deliberately offering a byte while `wr_ready` is low. Reads on an empty store are issued only with `wr_en` low, which matches the condition the stable-occupancy property relies on.

// File: rtl/vsf_pkg.sv
package vsf_pkg;

  typedef struct packed {
    logic talk;
    logic low;
    logic empty;
    logic ovf;
  } vsf_flags_t;

  localparam int STAT_W = 8;

  function automatic logic [STAT_W-1:0] pack_status(vsf_flags_t f);
    return {f.talk, f.low, f.empty, f.ovf, 4'b0000};
  endfunction

endpackage

// File: rtl/vsf_store.sv
module vsf_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] head
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_q, wr_d;
  logic [PTR_W-1:0]  rd_q, rd_d;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_d = wr_q;
    rd_d = rd_q;
    if (push) wr_d = bump(wr_q);
    if (pop)  rd_d = bump(rd_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      wr_q <= wr_d;
      rd_q <= rd_d;
    end
  end

  // storage cells carry no reset; each has its own write enable
  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    logic cell_we;
    assign cell_we = push && (wr_q == PTR_W'(i));
    always_ff @(posedge clk) begin
      if (cell_we) mem_q[i] <= wdata;
    end
  end

  assign head = mem_q[rd_q];

endmodule

// File: rtl/vsf_level.sv
module vsf_level #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  output logic [CNT_W-1:0] level,
  output logic             full,
  output logic             empty
);

  logic [CNT_W-1:0] lvl_q, lvl_d;

  always_comb begin
    lvl_d = lvl_q;
    unique case ({push, pop})
      2'b10:   lvl_d = lvl_q + 1'b1;
      2'b01:   lvl_d = lvl_q - 1'b1;
      default: lvl_d = lvl_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_d;
  end

  assign level = lvl_q;
  assign full  = (lvl_q == CNT_W'(DEPTH));
  assign empty = (lvl_q == '0);

endmodule

// File: rtl/vsf_status.sv
module vsf_status
  import vsf_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int LOW_MARK = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] level,
  input  logic             engine_idle,
  input  logic             drop,
  input  logic             clr_ovf,
  output vsf_flags_t       flags,
  output logic             irq
);

  logic ovf_q, ovf_d;
  logic is_zero;

  always_comb begin
    ovf_d = ovf_q;
    if (clr_ovf) ovf_d = 1'b0;
    if (drop)    ovf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= 1'b0;
    else        ovf_q <= ovf_d;
  end

  always_comb begin
    is_zero     = (level == '0);
    flags.empty = is_zero;
    flags.low   = !is_zero && (level <= CNT_W'(LOW_MARK));
    flags.talk  = is_zero && engine_idle;
    flags.ovf   = ovf_q;
    irq         = flags.talk | flags.low | flags.empty;
  end

endmodule

// File: rtl/voice_stage_fifo.sv
module voice_stage_fifo
  import vsf_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int DEPTH    = 16,
  parameter int LOW_MARK = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  input  logic              engine_idle,
  input  logic              stat_rd,
  output logic [STAT_W-1:0] stat_data,
  output logic              irq
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             rst_meta_q, rst_sync_n;
  logic             push, pop, drop;
  logic             full, empty;
  logic [CNT_W-1:0] level_q;
  vsf_flags_t       flags;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  assign push = wr_en && !full;
  assign drop = wr_en &&  full;
  assign pop  = rd_en && !empty;

  vsf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .push  (push),
    .pop   (pop),
    .wdata (wr_data),
    .head  (rd_data)
  );

  vsf_level #(.DEPTH(DEPTH)) u_level (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .push  (push),
    .pop   (pop),
    .level (level_q),
    .full  (full),
    .empty (empty)
  );

  vsf_status #(.DEPTH(DEPTH), .LOW_MARK(LOW_MARK)) u_status (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .level       (level_q),
    .engine_idle (engine_idle),
    .drop        (drop),
    .clr_ovf     (stat_rd),
    .flags       (flags),
    .irq         (irq)
  );

  assign wr_ready  = !full;
  assign rd_valid  = !empty;
  assign stat_data = pack_status(flags);

endmodule

// File: rtl/vsf_chk.sv
module vsf_chk #(
  parameter int DEPTH    = 16,
  parameter int LOW_MARK = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             wr_en,
  input logic             wr_ready,
  input logic             rd_en,
  input logic             rd_valid,
  input logic             stat_rd,
  input logic [7:0]       stat_data,
  input logic             irq,
  input logic [CNT_W-1:0] level_q
);

  // R7
  full_ready_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (level_q == CNT_W'(DEPTH)) |-> !wr_ready);

  // R6
  no_irq_above_mark_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (level_q > CNT_W'(LOW_MARK)) |-> !irq);

  // R10
  push_pop_level_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && wr_ready && rd_en && rd_valid) |=> $stable(level_q));

  // R8
  drop_sets_ovf_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && !wr_ready) |=> stat_data[4]);

  // R9
  read_clears_ovf_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (stat_rd && !(wr_en && !wr_ready)) |=> !stat_data[4]);

  // R11
  empty_pop_ignored_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_en && !rd_valid && !wr_en) |=> (level_q == '0));

  // R4
  empty_valid_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    stat_data[5] == !rd_valid);

endmodule

bind voice_stage_fifo vsf_chk #(.DEPTH(DEPTH), .LOW_MARK(LOW_MARK)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .wr_en      (wr_en),
  .wr_ready   (wr_ready),
  .rd_en      (rd_en),
  .rd_valid   (rd_valid),
  .stat_rd    (stat_rd),
  .stat_data  (stat_data),
  .irq        (irq),
  .level_q    (level_q)
);

// File: tb/voice_stage_fifo_tb.sv
`timescale 1ns/1ps
module voice_stage_fifo_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, rd_en, engine_idle, stat_rd;
  logic [7:0] wr_data;
  logic       wr_ready, rd_valid, irq;
  logic [7:0] rd_data, stat_data;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  voice_stage_fifo u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .wr_ready    (wr_ready),
    .rd_en       (rd_en),
    .rd_data     (rd_data),
    .rd_valid    (rd_valid),
    .engine_idle (engine_idle),
    .stat_rd     (stat_rd),
    .stat_data   (stat_data),
    .irq         (irq)
  );

  function automatic logic [7:0] exp_stat(int lvl, bit idle, bit ovf);
    return {idle && lvl == 0, lvl >= 1 && lvl <= 8, lvl == 0, ovf, 4'b0000};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic push(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic pop();
    rd_en = 1'b1;
    tick();
    rd_en = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 ready", wr_ready, 1);
    chk("R1 valid", rd_valid, 0);
    chk("R1 status", stat_data, 8'h20);
    chk("R4 irq on empty", irq, 1);
  endtask

  task automatic t_fill_drain();
    for (int i = 1; i <= 16; i++) begin
      push(8'hA0 + 8'(i));
      chk("R6 irq per write", irq, (i <= 8) ? 1 : 0);
      chk("R3 status per write", stat_data, exp_stat(i, 0, 0));
    end
    chk("R7 ready at full", wr_ready, 0);
    push(8'h33);
    chk("R8 overflow bit", stat_data, 8'h10);
    chk("R7 still full", wr_ready, 0);
    stat_rd = 1'b1;
    tick();
    stat_rd = 1'b0;
    chk("R9 overflow cleared", stat_data, 8'h00);
    chk("R9 occupancy kept", wr_ready, 0);
    for (int i = 1; i <= 16; i++) begin
      chk("R2 order", rd_data, 8'hA0 + 8'(i));
      pop();
      chk("R3 status per read", stat_data, exp_stat(16 - i, 0, 0));
    end
    chk("R4 valid after drain", rd_valid, 0);
  endtask

  task automatic t_pop_empty();
    pop();
    chk("R11 status after empty read", stat_data, 8'h20);
    push(8'h5A);
    chk("R11 valid", rd_valid, 1);
    chk("R11 head", rd_data, 8'h5A);
    pop();
    chk("R11 empty again", rd_valid, 0);
  endtask

  task automatic t_simul();
    push(8'h01); push(8'h02); push(8'h03);
    for (int i = 0; i < 4; i++) begin
      chk("R10 head", rd_data, 8'(i + 1));
      wr_en = 1'b1; wr_data = 8'(i + 4); rd_en = 1'b1;
      tick();
      wr_en = 1'b0; rd_en = 1'b0;
      chk("R10 status", stat_data, exp_stat(3, 0, 0));
    end
    for (int i = 0; i < 3; i++) begin
      chk("R10 drain order", rd_data, 8'(i + 5));
      pop();
    end
    chk("R10 empty after three", rd_valid, 0);
  endtask

  task automatic t_talk();
    engine_idle = 1'b1;
    #1;
    chk("R5 talk flag", stat_data, 8'hA0);
    chk("R6 irq talk", irq, 1);
    push(8'h77);
    chk("R5 talk off with data", stat_data, 8'h40);
    pop();
    chk("R5 talk back", stat_data, 8'hA0);
    engine_idle = 1'b0;
    #1;
    chk("R5 talk off when busy", stat_data, 8'h20);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    engine_idle = 1'b0; stat_rd = 1'b0; wr_data = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) tick();
    t_reset();
    t_fill_drain();
    t_pop_empty();
    t_simul();
    t_talk();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule